// File: doc/BRIEF.md
# Serial Word Shifter with Half-Word Packing

This block is the data path of a serial port. It moves words of programmable length over a one-bit line in each direction, and the bit order is selectable. A bit-clock enable marks the cycles on which a bit moves. A frame-start strobe, taken on such a cycle, marks the first bit of a word.

The receive side collects the incoming bits into a right-justified parallel word and presents it with a one-cycle valid pulse. With packing on, the receive side merges two successive short words into one full word. The transmit side takes a parallel word through a ready/valid handshake and shifts it out. With packing on, it sends the low half-word first and the high half-word second, each as a separate frame.

Both sides read the same length, order and packing controls. When packing is on, the length is capped at half the word width.

Top module: `sword_shifter`

## Requirements
- R1: The word length is `len_field + 1`, from 3 to 32 bits. A `len_field` value of 0 or 1 gives a 3-bit word. With `pack_en` = 1, lengths above 16 are treated as 16.
- R2: A received word is right-justified on `rx_data`. Every bit above the word length is 0.
- R3: With `lsb_first` = 0, both directions move the most significant bit of the word first. With `lsb_first` = 1, both directions move the least significant bit first.
- R4: With `pack_en` = 0, the receiver samples `ser_in` on each cycle where `bit_en` = 1. The first bit is the one sampled with `frame_start` = 1. `rx_valid` is high for exactly the one cycle after the edge that samples the last bit of the word. `rx_valid` stays low at all other times.
- R5: With `pack_en` = 1, `rx_valid` pulses only after the second word of a pair. The first word of the pair sits in bits 15..0 of `rx_data` and the second word in bits 31..16.
- R6: If `pack_en` is 0 for at least one cycle, any half-filled pair is discarded. After packing is turned back on, the next word received becomes the first word of a new pair.
- R7: A `frame_start` that arrives during a receive word abandons the partial word. The bit sampled with it becomes bit 0 of a new word.
- R8: `tx_ready` is 1 exactly when no transmit word is held. A word is taken on a cycle with `tx_valid` = 1 and `tx_ready` = 1, and `tx_ready` is 0 in the next cycle. While a word is held, `tx_data` is ignored.
- R9: The transmitter starts a word on a `bit_en` edge with `frame_start` = 1 and a word held. Bit 0 of the order appears on `ser_out` after that edge, and each later `bit_en` edge advances one bit. The edge after the last bit returns `ser_out` to 0.
- R10: With `pack_en` = 1, a held word is sent as two frames: bits 15..0 first, then bits 31..16. `tx_ready` returns to 1 only after the last bit of the second frame.
- R11: A frame start that arrives while no transmit word is held leaves `ser_out` at 0 and `tx_ready` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Bit-clock enable; one serial bit moves per asserted cycle |
| frame_start | input | 1 | First-bit marker, honoured when `bit_en` is also high |
| ser_in | input | 1 | Serial receive data |
| len_field | input | 5 | Word length minus one |
| lsb_first | input | 1 | Bit order: 0 = MSB first, 1 = LSB first |
| pack_en | input | 1 | Half-word packing enable |
| rx_data | output | 32 | Received word, right-justified |
| rx_valid | output | 1 | One-cycle pulse when `rx_data` holds a new word |
| tx_data | input | 32 | Word to transmit |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | Transmitter can take a word |
| ser_out | output | 1 | Serial transmit data |

## Verification
The bench builds the block with the default 32-bit word. This gives a 5-bit length field covering every legal length from 3 to 32, the two illegal field values, and 16-bit halves for packing.

With these values, the cap that packing puts on a 17-to-32-bit length falls inside the random stimulus. So do the full-width 32-bit shift and the mask edge where every bit is kept. Directed cases add the following:
- a receive restart in the middle of a word;
- a pair discarded when packing drops;
- a transmit word offered while the transmitter is busy;
- an empty transmit frame.

// File: rtl/swsh_pkg.sv
package swsh_pkg;
    localparam int unsigned DEF_WORD_W = 32;
    localparam int unsigned MIN_LEN    = 3;

    typedef enum logic {
        ORDER_MSB = 1'b0,
        ORDER_LSB = 1'b1
    } bit_order_e;
endpackage

// File: rtl/swsh_len.sv
module swsh_len
    import swsh_pkg::*;
#(
    parameter  int unsigned WORD_W = DEF_WORD_W,
    localparam int unsigned CNT_W  = $clog2(WORD_W),
    localparam int unsigned HALF_W = WORD_W / 2
) (
    input  logic [CNT_W-1:0] len_field,
    input  logic             pack_en,
    output logic [CNT_W-1:0] len_m1
);
    localparam logic [CNT_W-1:0] MIN_M1  = CNT_W'(MIN_LEN - 1);
    localparam logic [CNT_W-1:0] HALF_M1 = CNT_W'(HALF_W - 1);

    // Illegal short lengths clamp upward; packing caps at half a word.
    always_comb begin
        len_m1 = len_field;
        if (len_field < MIN_M1) begin
            len_m1 = MIN_M1;
        end
        if (pack_en && (len_m1 > HALF_M1)) begin
            len_m1 = HALF_M1;
        end
    end
endmodule

// File: rtl/swsh_rx.sv
module swsh_rx
    import swsh_pkg::*;
#(
    parameter  int unsigned WORD_W = DEF_WORD_W,
    localparam int unsigned CNT_W  = $clog2(WORD_W),
    localparam int unsigned HALF_W = WORD_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              frame_start,
    input  logic              ser_in,
    input  logic              lsb_first,
    input  logic              pack_en,
    input  logic [CNT_W-1:0]  len_m1,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_valid
);
    typedef struct packed {
        logic              active;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] sh;
        logic              half_have;
        logic [HALF_W-1:0] low;
        logic [WORD_W-1:0] data;
        logic              valid;
    } rx_state_t;

    rx_state_t q, d;

    logic [WORD_W-1:0] base;
    logic [WORD_W-1:0] nxt;
    logic [WORD_W-1:0] mask;
    logic [WORD_W-1:0] word;
    logic [CNT_W-1:0]  idx;
    logic              take;

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        base    = q.sh;
        idx     = q.cnt;
        take    = 1'b0;
        nxt     = '0;
        word    = '0;
        mask    = ~({WORD_W{1'b1}} << ({1'b0, len_m1} + (CNT_W+1)'(1)));

        if (!pack_en) begin
            d.half_have = 1'b0;
        end

        if (bit_en && frame_start) begin
            take = 1'b1;
            base = '0;
            idx  = '0;
        end else if (bit_en && q.active) begin
            take = 1'b1;
        end

        if (take) begin
            if (bit_order_e'(lsb_first) == ORDER_LSB) begin
                nxt      = base;
                nxt[idx] = ser_in;
            end else begin
                nxt = {base[WORD_W-2:0], ser_in};
            end

            if (idx == len_m1) begin
                d.active = 1'b0;
                d.cnt    = '0;
                d.sh     = '0;
                word     = nxt & mask;
                if (pack_en) begin
                    if (q.half_have) begin
                        d.data      = {word[HALF_W-1:0], q.low};
                        d.valid     = 1'b1;
                        d.half_have = 1'b0;
                    end else begin
                        d.low       = word[HALF_W-1:0];
                        d.half_have = 1'b1;
                    end
                end else begin
                    d.data  = word;
                    d.valid = 1'b1;
                end
            end else begin
                d.active = 1'b1;
                d.cnt    = idx + CNT_W'(1);
                d.sh     = nxt;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rx_data  = q.data;
    assign rx_valid = q.valid;

    AST_RX_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R4
    AST_RX_VALID_AFTER_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bit_en) |-> !rx_valid); // R4
    AST_RX_PAIR_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && $past(pack_en)) |-> $past(q.half_have)); // R5
    AST_RX_HALF_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pack_en) |-> !q.half_have); // R6
endmodule

// File: rtl/swsh_tx.sv
module swsh_tx
    import swsh_pkg::*;
#(
    parameter  int unsigned WORD_W = DEF_WORD_W,
    localparam int unsigned CNT_W  = $clog2(WORD_W),
    localparam int unsigned HALF_W = WORD_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              frame_start,
    input  logic              lsb_first,
    input  logic              pack_en,
    input  logic [CNT_W-1:0]  len_m1,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              ser_out
);
    typedef struct packed {
        logic              full;
        logic [WORD_W-1:0] word;
        logic              half;
        logic              active;
        logic [CNT_W-1:0]  cnt;
    } tx_state_t;

    tx_state_t q, d;

    logic [WORD_W-1:0] src;
    logic [CNT_W-1:0]  pos;

    // Serial output follows the registered bit pointer.
    always_comb begin
        if (q.half) begin
            src = {{HALF_W{1'b0}}, q.word[WORD_W-1:HALF_W]};
        end else if (pack_en) begin
            src = {{HALF_W{1'b0}}, q.word[HALF_W-1:0]};
        end else begin
            src = q.word;
        end
        if (bit_order_e'(lsb_first) == ORDER_LSB) begin
            pos = q.cnt;
        end else begin
            pos = len_m1 - q.cnt;
        end
    end

    assign ser_out  = q.active & src[pos];
    assign tx_ready = ~q.full;

    always_comb begin
        d = q;
        if (tx_valid && !q.full) begin
            d.full = 1'b1;
            d.word = tx_data;
            d.half = 1'b0;
        end
        if (bit_en) begin
            if (q.active) begin
                if (q.cnt == len_m1) begin
                    d.active = 1'b0;
                    d.cnt    = '0;
                    if (pack_en && !q.half) begin
                        d.half = 1'b1;
                    end else begin
                        d.full = 1'b0;
                        d.half = 1'b0;
                    end
                end else begin
                    d.cnt = q.cnt + CNT_W'(1);
                end
            end else if (frame_start && q.full) begin
                d.active = 1'b1;
                d.cnt    = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    AST_TX_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> !ser_out); // R9
    AST_TX_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_ready); // R8
    AST_TX_READY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_ready) |-> ($past(q.active) && $past(bit_en))); // R10
    AST_TX_WORD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_ready && $past(!tx_ready)) |-> $stable(q.word)); // R8
endmodule

// File: rtl/sword_shifter.sv
module sword_shifter
    import swsh_pkg::*;
#(
    parameter  int unsigned WORD_W = DEF_WORD_W,
    localparam int unsigned CNT_W  = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              frame_start,
    input  logic              ser_in,
    input  logic [CNT_W-1:0]  len_field,
    input  logic              lsb_first,
    input  logic              pack_en,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              ser_out
);
    logic [CNT_W-1:0] len_m1;

    swsh_len #(.WORD_W(WORD_W)) i_len (
        .len_field (len_field),
        .pack_en   (pack_en),
        .len_m1    (len_m1)
    );

    swsh_rx #(.WORD_W(WORD_W)) i_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_en      (bit_en),
        .frame_start (frame_start),
        .ser_in      (ser_in),
        .lsb_first   (lsb_first),
        .pack_en     (pack_en),
        .len_m1      (len_m1),
        .rx_data     (rx_data),
        .rx_valid    (rx_valid)
    );

    swsh_tx #(.WORD_W(WORD_W)) i_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_en      (bit_en),
        .frame_start (frame_start),
        .lsb_first   (lsb_first),
        .pack_en     (pack_en),
        .len_m1      (len_m1),
        .tx_data     (tx_data),
        .tx_valid    (tx_valid),
        .tx_ready    (tx_ready),
        .ser_out     (ser_out)
    );
endmodule

// File: tb/test_sword_shifter.sv
`timescale 1ns/1ps
module test_sword_shifter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_en = 1'b0;
    logic        frame_start = 1'b0;
    logic        ser_in = 1'b0;
    logic [4:0]  len_field = 5'd7;
    logic        lsb_first = 1'b0;
    logic        pack_en = 1'b0;
    logic [31:0] rx_data;
    logic        rx_valid;
    logic [31:0] tx_data = '0;
    logic        tx_valid = 1'b0;
    logic        tx_ready;
    logic        ser_out;

    int vectors = 0;
    int fails = 0;

    always #4 clk = ~clk;

    sword_shifter i_sword_shifter (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .frame_start(frame_start),
        .ser_in(ser_in), .len_field(len_field), .lsb_first(lsb_first),
        .pack_en(pack_en), .rx_data(rx_data), .rx_valid(rx_valid),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .ser_out(ser_out)
    );

    function automatic int eff_len(int f, bit pk);
        int l;
        l = (f < 2) ? 3 : f + 1;
        if (pk && l > 16) l = 16;
        return l;
    endfunction

    function automatic logic [31:0] lowmask(int l);
        return (l >= 32) ? 32'hFFFF_FFFF : ((32'd1 << l) - 32'd1);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(bit fs, bit b);
        bit_en = 1'b1; frame_start = fs; ser_in = b;
        @(posedge clk); #1;
        bit_en = 1'b0; frame_start = 1'b0; ser_in = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic set_cfg(int f, bit lsb, bit pk);
        pack_en = 1'b0; len_field = 5'(f); lsb_first = lsb;
        idle(1);
        pack_en = pk;
        idle(1);
    endtask

    task automatic rx_send(logic [31:0] v, int l, bit lsb, bit gaps);
        for (int k = 0; k < l; k++) begin
            step(k == 0, lsb ? v[k] : v[l-1-k]);
            if (gaps && k != l-1 && ($urandom % 3) == 0) idle(1);
        end
    endtask

    task automatic rx_single(string req, logic [31:0] v, int f, bit lsb, bit gaps);
        int l;
        l = eff_len(f, 1'b0);
        rx_send(v, l, lsb, gaps);
        chk({req, " rx_valid"}, 32'(rx_valid), 32'd1);
        chk({req, " rx_data"}, rx_data, v & lowmask(l));
        idle(1);
        chk({req, " R4 pulse end"}, 32'(rx_valid), 32'd0);
    endtask

    task automatic rx_pair(string req, logic [31:0] a, logic [31:0] b, int f, bit lsb, bit gaps);
        int l;
        logic [31:0] m;
        l = eff_len(f, 1'b1);
        m = lowmask(l);
        rx_send(a, l, lsb, gaps);
        chk({req, " R5 no valid on first"}, 32'(rx_valid), 32'd0);
        rx_send(b, l, lsb, gaps);
        chk({req, " R5 rx_valid"}, 32'(rx_valid), 32'd1);
        chk({req, " R5 rx_data"}, rx_data, {b[15:0] & m[15:0], a[15:0] & m[15:0]});
        idle(1);
    endtask

    task automatic tx_put(string req, logic [31:0] w);
        chk({req, " R8 ready before"}, 32'(tx_ready), 32'd1);
        tx_data = w; tx_valid = 1'b1;
        @(posedge clk); #1;
        tx_valid = 1'b0;
        chk({req, " R8 ready drops"}, 32'(tx_ready), 32'd0);
    endtask

    task automatic tx_frame(string req, logic [31:0] w, int f, bit lsb, bit pk, bit half);
        int l;
        logic [31:0] src;
        l = eff_len(f, pk);
        src = half ? {16'h0, w[31:16]} : (pk ? {16'h0, w[15:0]} : w);
        for (int k = 0; k < l; k++) begin
            step(k == 0, 1'b0);
            chk($sformatf("%s R9 bit %0d", req, k), 32'(ser_out),
                32'(lsb ? src[k] : src[l-1-k]));
        end
        step(1'b0, 1'b0);
        chk({req, " R9 low after"}, 32'(ser_out), 32'd0);
        chk({req, " R10 ready after"}, 32'(tx_ready), (pk && !half) ? 32'd0 : 32'd1);
    endtask

    task automatic tx_word(string req, logic [31:0] w, int f, bit lsb, bit pk);
        tx_put(req, w);
        tx_frame(req, w, f, lsb, pk, 1'b0);
        if (pk) tx_frame({req, " R10 high half"}, w, f, lsb, pk, 1'b1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        idle(3);
        rst_n = 1'b1;
        idle(1);
        chk("reset rx_valid", 32'(rx_valid), 32'd0);
        chk("reset R8 tx_ready", 32'(tx_ready), 32'd1);
        chk("reset ser_out", 32'(ser_out), 32'd0);

        // R3 R4 directed receive
        set_cfg(7, 1'b0, 1'b0);
        rx_single("R3 msb", 32'hFFFF_FFA5, 7, 1'b0, 1'b0);
        set_cfg(7, 1'b1, 1'b0);
        rx_single("R3 lsb", 32'h0000_001D, 7, 1'b1, 1'b0);
        // R1 clamp and full width, R2 zero fill
        set_cfg(0, 1'b0, 1'b0);
        rx_single("R1 f0", 32'hFFFF_FFFD, 0, 1'b0, 1'b0);
        set_cfg(1, 1'b1, 1'b0);
        rx_single("R1 f1", 32'h0000_0006, 1, 1'b1, 1'b0);
        set_cfg(31, 1'b0, 1'b0);
        rx_single("R1 R2 f31", 32'hDEAD_BEEF, 31, 1'b0, 1'b1);
        // R7 restart mid-word
        set_cfg(11, 1'b0, 1'b0);
        step(1'b1, 1'b1); step(1'b0, 1'b0); step(1'b0, 1'b1);
        rx_single("R7 restart", 32'h0000_05A3, 11, 1'b0, 1'b0);
        // R5 packing
        set_cfg(15, 1'b0, 1'b1);
        rx_pair("pack16", 32'h0000_1234, 32'h0000_ABCD, 15, 1'b0, 1'b0);
        set_cfg(9, 1'b1, 1'b1);
        rx_pair("pack10", 32'h0000_0155, 32'h0000_02F0, 9, 1'b1, 1'b0);
        set_cfg(31, 1'b0, 1'b1);
        rx_pair("R1 pack cap", 32'h7777_8001, 32'h1111_4002, 31, 1'b0, 1'b0);
        // R6 discard half pair
        set_cfg(7, 1'b0, 1'b1);
        rx_send(32'h11, 8, 1'b0, 1'b0);
        chk("R6 first half", 32'(rx_valid), 32'd0);
        pack_en = 1'b0; idle(1); pack_en = 1'b1; idle(1);
        rx_pair("R6 after drop", 32'h22, 32'h33, 7, 1'b0, 1'b0);

        // R11 empty frame
        set_cfg(7, 1'b0, 1'b0);
        for (int k = 0; k < 9; k++) begin
            step(k == 0, 1'b0);
            chk("R11 ser_out", 32'(ser_out), 32'd0);
        end
        chk("R11 tx_ready", 32'(tx_ready), 32'd1);
        // R8 busy offer ignored
        tx_put("R8 hold", 32'h0000_00C3);
        tx_data = 32'h0000_00FF; tx_valid = 1'b1; idle(1); tx_valid = 1'b0;
        tx_frame("R8 ignored", 32'h0000_00C3, 7, 1'b0, 1'b0, 1'b0);
        set_cfg(4, 1'b1, 1'b0);
        tx_word("R3 tx lsb", 32'h0000_0016, 4, 1'b1, 1'b0);
        set_cfg(31, 1'b0, 1'b0);
        tx_word("R1 tx 32", 32'h8000_0001, 31, 1'b0, 1'b0);
        set_cfg(0, 1'b0, 1'b0);
        tx_word("R1 tx f0", 32'hFFFF_FFF4, 0, 1'b0, 1'b0);
        set_cfg(15, 1'b0, 1'b1);
        tx_word("R10 tx pack", 32'hBEEF_1234, 15, 1'b0, 1'b1);

        // random receive
        for (int i = 0; i < 40; i++) begin
            int f; bit lsb; bit pk;
            f = int'($urandom % 32); lsb = 1'($urandom); pk = 1'($urandom);
            set_cfg(f, lsb, pk);
            if (pk) rx_pair("R5 rand", $urandom, $urandom, f, lsb, 1'b1);
            else rx_single("R2 rand", $urandom, f, lsb, 1'b1);
        end
        // random transmit
        for (int i = 0; i < 30; i++) begin
            int f; bit lsb; bit pk;
            f = int'($urandom % 32); lsb = 1'($urandom); pk = 1'($urandom);
            set_cfg(f, lsb, pk);
            tx_word("R9 rand", $urandom, f, lsb, pk);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule